// File: doc/BRIEF.md
# Multi-channel link error aggregator

This block gathers the error flags that ride along with the final stored word of every input link channel and turns them into three results: a map with one bit per channel that saw an error, a 4-bit link error code that ORs each error kind across all channels, and a single flag that asks for raw data to be read out because an enabled channel reported an error. The flags are taken in only when a capture strobe marks the last word of a frame. Between strobes the inputs may change freely without any effect on the results.

The three results are packed into one fixed-width record for a downstream error FIFO. A write strobe for that record follows the capture strobe by a fixed number of cycles. A per-channel enable mask decides which links can raise the readout request. Channels that are disabled are still reported in the map and in the link code. Neither the FIFO nor any register access is part of this block.

Top module: `link_err_aggregator`

## Requirements
- R1: The channel count `N_CH` is a parameter with a default of 49. Channel i drives bits [36*i+35 : 36*i] of the flat word bus, and its error field is the top nibble of that word, bits 35:32. Within that nibble, bit 34 is CRC, bit 33 is disparity, bit 32 is not-in-table, and bit 35 is ignored.
- R2: Results change only on a clock edge at which `cap_strobe_i` is high. The new values appear at the outputs in the cycle after that edge.
- R3: `link_code_o` bit 3 is always 0. Bits 2, 1 and 0 (CRC, disparity, not-in-table) are each the OR of that error kind over all channels at capture time, whatever the mask says.
- R4: `chan_map_o` bit i is 1 exactly when channel i had any of its CRC, disparity or not-in-table bits set at capture, whatever the mask says.
- R5: `req_o` is 1 exactly when at least one channel whose `chan_en_i` bit was 1 at capture had an error.
- R6: Between captures, all results hold their values even when the words and the mask change.
- R7: `record_o` equals {req, link code, map}: the request sits at bit 53, the code at bits 52:49 and the map at bits 48:0 (for N_CH = 49).
- R8: `record_wr_o` is high for exactly one cycle, four cycles after each cycle in which the strobe was high. Back-to-back strobes give back-to-back write pulses.
- R9: Synchronous active-low reset clears the map, code, request, record and any write pulse still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_strobe_i | input | 1 | Marks the last word of a frame; captures the flags |
| chan_words_i | input | 36*N_CH | Stored word of every channel, channel 0 in the low bits |
| chan_en_i | input | N_CH | Channels allowed to raise the readout request |
| chan_map_o | output | N_CH | Per-channel error map |
| link_code_o | output | 4 | OR of each error kind over all channels; MSB always 0 |
| req_o | output | 1 | Raw readout on error request |
| record_o | output | N_CH+5 | Packed record {req, code, map} |
| record_wr_o | output | 1 | Record write strobe, four cycles after capture |

## Verification
The map, code, request and record are registered once. They are due in the cycle after the strobe edge and must stay unchanged until the next strobe. The write pulse passes through four registers, so it is due in the fourth cycle after the strobe cycle. The bench drives inputs and compares outputs on the falling edge. After each modelled rising edge it advances its own model, which is a set of captured values plus a four-deep pipe of past strobes, so every comparison matches the register count. Reset is applied while a write pulse is still in the pipe, and the bench checks that no pulse then appears.

// File: rtl/lerr_pkg.sv
// Package: shared widths and the link error code layout.
// Assumes every channel word is 36 bits with the error nibble on top.
package lerr_pkg;
    localparam int unsigned LERR_WORD_W  = 36;
    localparam int unsigned LERR_ERR_LSB = 32;
    localparam int unsigned LERR_KINDS   = 3;
    localparam int unsigned LERR_CODE_W  = 4;

    // Link error code, MSB first: constant zero, CRC, disparity, not-in-table.
    typedef struct packed {
        logic pad_zero;
        logic crc;
        logic disp;
        logic nit;
    } lerr_code_t;
endpackage

// File: rtl/lerr_field_extract.sv
// Module: lerr_field_extract
// Slices the three live error bits out of every channel word.
// Assumes channel i sits at bits [WORD_W*i +: WORD_W] of the flat bus;
// the top nibble bit is not an error kind and is dropped here.
module lerr_field_extract
    import lerr_pkg::*;
#(
    parameter int unsigned N_CH = 49
) (
    input  logic [N_CH*LERR_WORD_W-1:0]    words_i,
    output logic [N_CH-1:0][LERR_KINDS-1:0] kinds_o
);
    genvar ch;
    generate
        for (ch = 0; ch < N_CH; ch++) begin : g_slice
            // Per-channel slice of CRC, disparity and not-in-table bits.
            assign kinds_o[ch] = words_i[ch*LERR_WORD_W + LERR_ERR_LSB +: LERR_KINDS];
        end
    endgenerate
endmodule

// File: rtl/lerr_reduce.sv
// Module: lerr_reduce
// Combinational reduction: per-channel map, per-kind OR code and the
// masked readout request. Assumes inputs are stable for the capture edge.
module lerr_reduce
    import lerr_pkg::*;
#(
    parameter int unsigned N_CH = 49
) (
    input  logic [N_CH-1:0][LERR_KINDS-1:0] kinds_i,
    input  logic [N_CH-1:0]                 en_i,
    output logic [N_CH-1:0]                 map_o,
    output lerr_code_t                      code_o,
    output logic                            req_o
);
    // Map bit per channel: any live error kind.
    always_comb begin
        for (int ch = 0; ch < int'(N_CH); ch++) begin
            map_o[ch] = |kinds_i[ch];
        end
    end

    // Per-kind OR across all channels, unmasked; top bit held at zero.
    always_comb begin
        code_o = '0;
        for (int ch = 0; ch < int'(N_CH); ch++) begin
            code_o.crc  = code_o.crc  | kinds_i[ch][2];
            code_o.disp = code_o.disp | kinds_i[ch][1];
            code_o.nit  = code_o.nit  | kinds_i[ch][0];
        end
    end

    // Request only from channels the mask enables.
    assign req_o = |(map_o & en_i);
endmodule

// File: rtl/lerr_strobe_delay.sv
// Module: lerr_strobe_delay
// Fixed-depth shift register that delays the capture strobe into the
// record write strobe. Assumes DEPTH >= 1; reset clears pulses in flight.
module lerr_strobe_delay #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic pulse_o
);
    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            // Single stage: register the strobe once.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= pulse_i;
            end
        end else begin : g_chain
            // Multi-stage: shift the strobe toward the MSB each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[DEPTH-2:0], pulse_i};
            end
        end
    endgenerate

    assign pulse_o = stage_q[DEPTH-1];
endmodule

// File: rtl/link_err_aggregator.sv
// Module: link_err_aggregator (top)
// Captures per-channel error nibbles on an end-of-frame strobe and
// produces a channel map, an OR'd link code, a masked readout request
// and a packed record {req, code, map} with a delayed write strobe.
// Assumes a single clock and a synchronous active-low reset.
module link_err_aggregator
    import lerr_pkg::*;
#(
    parameter int unsigned N_CH     = 49,
    parameter int unsigned WR_DELAY = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap_strobe_i,
    input  logic [N_CH*LERR_WORD_W-1:0]   chan_words_i,
    input  logic [N_CH-1:0]               chan_en_i,
    output logic [N_CH-1:0]               chan_map_o,
    output logic [LERR_CODE_W-1:0]        link_code_o,
    output logic                          req_o,
    output logic [N_CH+LERR_CODE_W:0]     record_o,
    output logic                          record_wr_o
);
    localparam int unsigned REC_W = 1 + LERR_CODE_W + N_CH;

    logic [N_CH-1:0][LERR_KINDS-1:0] kinds_c;
    logic [N_CH-1:0]                 map_c;
    lerr_code_t                      code_c;
    logic                            req_c;

    logic [N_CH-1:0] map_q;
    lerr_code_t      code_q;
    logic            req_q;

    lerr_field_extract #(.N_CH(N_CH)) u_extract (
        .words_i (chan_words_i),
        .kinds_o (kinds_c)
    );

    lerr_reduce #(.N_CH(N_CH)) u_reduce (
        .kinds_i (kinds_c),
        .en_i    (chan_en_i),
        .map_o   (map_c),
        .code_o  (code_c),
        .req_o   (req_c)
    );

    lerr_strobe_delay #(.DEPTH(WR_DELAY)) u_wr_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (cap_strobe_i),
        .pulse_o (record_wr_o)
    );

    // Capture registers: load on the strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= '0;
            code_q <= '0;
            req_q  <= 1'b0;
        end else if (cap_strobe_i) begin
            map_q  <= map_c;
            code_q <= code_c;
            req_q  <= req_c;
        end
    end

    assign chan_map_o  = map_q;
    assign link_code_o = code_q;
    assign req_o       = req_q;
    assign record_o    = REC_W'({req_q, code_q, map_q});

    // R6: with no strobe, the captured results keep their values.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe_i |=> ($stable(chan_map_o) && $stable(link_code_o) && $stable(req_o)));

    // R5: a request can only exist when some channel is in the map.
    p_req_needs_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (chan_map_o != '0));

    // R3: the link code is nonzero exactly when the map is nonzero, and its MSB stays clear.
    p_code_vs_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_code_o != '0) == (chan_map_o != '0)) && !link_code_o[LERR_CODE_W-1]);

    // R9: a reset cycle leaves every result and the write strobe cleared.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (chan_map_o == '0 && !req_o && link_code_o == '0 && !record_wr_o));
endmodule

// File: tb/link_err_aggregator_tb_top.sv
module link_err_aggregator_tb_top;
    localparam int N     = 49;
    localparam int WW    = 36;
    localparam int CLK_P = 10;
    localparam int REC_W = N + 5;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cap;
    logic [N*WW-1:0]    words;
    logic [N-1:0]       mask;
    logic [N-1:0]       map_o;
    logic [3:0]         code_o;
    logic               req_o;
    logic [REC_W-1:0]   rec_o;
    logic               wr_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [N-1:0] e_map;
    logic [3:0]   e_code;
    logic         e_req;
    logic [3:0]   e_pipe;

    always #(CLK_P/2) clk = ~clk;

    link_err_aggregator dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_strobe_i (cap),
        .chan_words_i (words),
        .chan_en_i    (mask),
        .chan_map_o   (map_o),
        .link_code_o  (code_o),
        .req_o        (req_o),
        .record_o     (rec_o),
        .record_wr_o  (wr_o)
    );

    function automatic logic [N-1:0] f_map(input logic [N*WW-1:0] w);
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = |w[i*WW+32 +: 3];
        return m;
    endfunction

    function automatic logic [3:0] f_code(input logic [N*WW-1:0] w);
        logic [3:0] c = 4'd0;
        for (int i = 0; i < N; i++) c[2:0] = c[2:0] | w[i*WW+32 +: 3];
        return c;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: check outputs now, drive inputs, then model the next edge.
    task automatic cycle(input logic rn, input logic c, input logic [N*WW-1:0] w, input logic [N-1:0] m);
        @(negedge clk);
        chk("R4 map", 64'(map_o), 64'(e_map));
        chk("R3 code", 64'(code_o), 64'(e_code));
        chk("R5 req", 64'(req_o), 64'(e_req));
        chk("R7 record", 64'(rec_o), 64'({e_req, e_code, e_map}));
        chk("R8 write strobe", 64'(wr_o), 64'(e_pipe[3]));
        rst_n = rn; cap = c; words = w; mask = m;
        if (!rn) begin
            e_map = '0; e_code = '0; e_req = 1'b0; e_pipe = '0;
        end else begin
            if (c) begin
                e_map  = f_map(w);
                e_code = f_code(w);
                e_req  = |(f_map(w) & m);
            end
            e_pipe = {e_pipe[2:0], c};
        end
    endtask

    function automatic logic [N*WW-1:0] rand_words(input int pct);
        logic [N*WW-1:0] w;
        for (int i = 0; i < N; i++) begin
            w[i*WW +: 32]   = $urandom;
            w[i*WW+32 +: 4] = (($urandom % 100) < pct) ? 4'($urandom) : {1'($urandom), 3'b000};
        end
        return w;
    endfunction

    function automatic logic [N-1:0] rand_mask();
        return {$urandom, $urandom};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [N*WW-1:0] w;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; cap = 1'b0; words = '0; mask = '0;
        e_map = '0; e_code = '0; e_req = 1'b0; e_pipe = '0;
        // R9 reset state
        cycle(1'b0, 1'b0, '0, '0);
        cycle(1'b0, 1'b0, '0, '0);
        cycle(1'b1, 1'b0, '0, '0);

        // R1 R4 R5: top channel error, enabled -> request
        w = '0; w[(N-1)*WW+34] = 1'b1;
        cycle(1'b1, 1'b1, w, {1'b1, {(N-1){1'b0}}});
        // R6: inputs change, no strobe -> hold
        cycle(1'b1, 1'b0, '1, '1);
        for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, rand_words(50), rand_mask());

        // R5: channel 0 error but masked -> map set, no request
        w = '0; w[33] = 1'b1;
        cycle(1'b1, 1'b1, w, {{(N-1){1'b1}}, 1'b0});
        for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, '0, '0);

        // R1 R3: only bit 35 set everywhere -> ignored
        w = '0; for (int i = 0; i < N; i++) w[i*WW+35] = 1'b1;
        cycle(1'b1, 1'b1, w, '1);
        for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, '0, '0);

        // R3 R4: all kinds everywhere
        cycle(1'b1, 1'b1, '1, '1);
        // R8: back-to-back strobes
        cycle(1'b1, 1'b1, rand_words(20), rand_mask());
        cycle(1'b1, 1'b1, rand_words(20), rand_mask());
        for (int k = 0; k < 6; k++) cycle(1'b1, 1'b0, rand_words(20), rand_mask());

        // R9: reset while write pulses are in flight
        cycle(1'b1, 1'b1, rand_words(30), '1);
        cycle(1'b1, 1'b0, '0, '0);
        cycle(1'b0, 1'b0, '0, '0);
        for (int k = 0; k < 6; k++) cycle(1'b1, 1'b0, '0, '0);

        // R2 R6 R8: random traffic
        for (int k = 0; k < 2000; k++) begin
            cycle(1'b1, (($urandom % 4) == 0), rand_words(3), rand_mask());
        end
        for (int k = 0; k < 6; k++) cycle(1'b1, 1'b0, '0, '0);
        finish_run();
    end
endmodule